// File: doc/BRIEF.md
# SPI Opcode-Queue Sequencer

This block is a single-lane SPI master that software drives through two queues instead of byte-by-byte register pokes. One queue holds command entries, each pairing a small operation code with a byte count. The other is a byte queue shared by both directions: software loads transmit bytes into it, and the master deposits received bytes into it for software to collect. A sequencer takes one command at a time from the head of the command queue. It asserts or releases chip select, clocks out the stated number of bytes from the byte queue, or clocks in the stated number of bytes into the byte queue.

A transaction is scripted as a list of entries: a select entry, an opcode byte, address and dummy bytes, a data phase, and a release entry. Software keeps the byte queue fed, or drained, by polling its full and empty flags. A phase longer than 511 bytes is split over several entries. The serial clock runs at the system clock divided by a parameter. It stops, low, whenever the sequencer waits on the byte queue.

Top module: `spi_opseq`

## Requirements
- R1: A command entry is 14 bits, with the byte count in bits [8:0] and the operation code in bits [13:9]. A write to the entry register (index 0) only stages the entry. The entry joins the command queue when 1 is written to bit 0 of the push register (index 1).
- R2: Bit 0 of read-only registers reports status: index 2 is command queue full, index 3 is command queue empty, index 5 is byte queue full, index 7 is byte queue empty.
- R3: Code 0x01 with count 1 drives `spi_cs_n` low. Code 0x00 with count 1 drives it high. Neither produces any serial clock edge.
- R4: Code 0x08 sends `count` bytes taken from the byte queue, MSB first, in SPI mode 0. SCLK idles low, MOSI changes only while SCLK is low, and consecutive rising edges within a byte are `CLK_DIV` system clocks apart.
- R5: Code 0x0C receives `count` bytes, sampling MISO on SCLK rising edges, MSB first. The bytes are appended to the byte queue in order. Index 6 shows the head byte, and writing 1 to bit 0 of index 8 removes it.
- R6: When a send finds the byte queue empty, the sequencer waits with SCLK low and continues once a byte arrives.
- R7: When a received byte finds the byte queue full, it is held and SCLK stays low until software frees a slot. No byte is lost.
- R8: An entry with count 0, with an unknown code, or with a chip-select code and a count other than 1 is removed from the queue. It produces no SCLK edge and leaves chip select unchanged.
- R9: The command queue holds `OP_DEPTH` entries. A push while it is full is ignored.
- R10: The byte queue holds `DAT_DEPTH` bytes. A software write (index 4) while it is full is ignored, and a removal while it is empty is ignored.
- R11: After reset, chip select is high, SCLK and MOSI are low, and both queues are empty and not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register index |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Read data for the register at `bus_addr` (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its defaults: an 8-entry command queue, a 16-byte byte queue and a clock divide of 4. At these sizes both queue-full conditions are reached after a handful of register writes. Eight queued sends behind a stalled one fill the command queue. A 16-byte write fills the byte queue, and an 18-byte receive stalls on a full byte queue within about 600 cycles. A divide of 4 keeps each byte at 32 system clocks, so multi-byte scripts finish quickly while the SCLK period stays measurable against the system clock.

// File: rtl/spi_opseq_pkg.sv
`timescale 1ns/1ps
package spi_opseq_pkg;

    localparam int LEN_W  = 9;
    localparam int CODE_W = 5;
    localparam int OP_W   = LEN_W + CODE_W;
    localparam int BYTE_W = 8;
    localparam int REG_AW = 4;

    // code occupies the upper bits of the entry, count the lower bits
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
    } op_entry_t;

    typedef enum logic [CODE_W-1:0] {
        OPC_CS_HIGH = 5'h00,
        OPC_CS_LOW  = 5'h01,
        OPC_SEND    = 5'h08,
        OPC_RECV    = 5'h0C
    } opc_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_SHIFT,
        SQ_STORE
    } sq_state_e;

    // register indices
    localparam logic [REG_AW-1:0] RI_OP_WORD  = 4'd0;
    localparam logic [REG_AW-1:0] RI_OP_PUSH  = 4'd1;
    localparam logic [REG_AW-1:0] RI_OP_FULL  = 4'd2;
    localparam logic [REG_AW-1:0] RI_OP_EMPTY = 4'd3;
    localparam logic [REG_AW-1:0] RI_DAT_IN   = 4'd4;
    localparam logic [REG_AW-1:0] RI_DAT_FULL = 4'd5;
    localparam logic [REG_AW-1:0] RI_DAT_OUT  = 4'd6;
    localparam logic [REG_AW-1:0] RI_DAT_EMPT = 4'd7;
    localparam logic [REG_AW-1:0] RI_DAT_NEXT = 4'd8;

    function automatic logic is_cs_cmd(op_entry_t e);
        return ((e.code == OPC_CS_LOW) || (e.code == OPC_CS_HIGH)) &&
               (e.len == LEN_W'(1));
    endfunction

    function automatic logic is_xfer_cmd(op_entry_t e);
        return ((e.code == OPC_SEND) || (e.code == OPC_RECV)) &&
               (e.len != '0);
    endfunction

endpackage

// File: rtl/spi_opseq_fifo.sv
`timescale 1ns/1ps
module spi_opseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R9 / R10: a push against a full queue leaves it untouched
    a_r9_full_push_ignored: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (full && $stable(wp)));

    a_r10_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (empty && $stable(rp)));

endmodule

// File: rtl/spi_opseq_regs.sv
`timescale 1ns/1ps
module spi_opseq_regs
    import spi_opseq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              op_full,
    input  logic              op_empty,
    input  logic              dat_full,
    input  logic              dat_empty,
    input  logic [BYTE_W-1:0] dat_head,
    output logic              op_push,
    output op_entry_t         op_word,
    output logic              sw_push,
    output logic [BYTE_W-1:0] sw_byte,
    output logic              sw_pop
);
    op_entry_t op_hold;
    logic      unused_wdata;

    assign unused_wdata = ^bus_wdata[DW-1:OP_W];

    always_ff @(posedge clk) begin
        if (rst)
            op_hold <= '0;
        else if (bus_wen && bus_addr == RI_OP_WORD)
            op_hold <= op_entry_t'(bus_wdata[OP_W-1:0]);
    end

    assign op_word = op_hold;
    assign op_push = bus_wen && (bus_addr == RI_OP_PUSH) && bus_wdata[0];
    assign sw_push = bus_wen && (bus_addr == RI_DAT_IN);
    assign sw_byte = bus_wdata[BYTE_W-1:0];
    assign sw_pop  = bus_wen && (bus_addr == RI_DAT_NEXT) && bus_wdata[0];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RI_OP_WORD:  bus_rdata = {{(DW-OP_W){1'b0}}, op_hold};
            RI_OP_FULL:  bus_rdata[0] = op_full;
            RI_OP_EMPTY: bus_rdata[0] = op_empty;
            RI_DAT_FULL: bus_rdata[0] = dat_full;
            RI_DAT_OUT:  bus_rdata = {{(DW-BYTE_W){1'b0}}, dat_head};
            RI_DAT_EMPT: bus_rdata[0] = dat_empty;
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_opseq_engine.sv
`timescale 1ns/1ps
module spi_opseq_engine
    import spi_opseq_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  op_entry_t         op_head,
    input  logic              op_empty,
    output logic              op_pop,
    input  logic [BYTE_W-1:0] d_head,
    input  logic              d_empty,
    input  logic              d_full,
    output logic              d_pop,
    output logic              d_push,
    output logic [BYTE_W-1:0] d_push_data,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int HALF = (CLK_DIV >= 2) ? CLK_DIV / 2 : 1;
    localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BCW  = $clog2(BYTE_W);

    sq_state_e         state;
    logic              sending;
    logic [LEN_W-1:0]  remain;
    logic [BYTE_W-1:0] shreg;
    logic              samp;
    logic [BCW-1:0]    bitc;
    logic [HCW-1:0]    hcnt;
    logic              sclk_q;
    logic              cs_q;

    assign op_pop      = (state == SQ_IDLE) && !op_empty;
    assign d_pop       = (state == SQ_LOAD) && sending && (remain != '0) && !d_empty;
    assign d_push      = (state == SQ_STORE) && !d_full;
    assign d_push_data = shreg;
    assign sclk        = sclk_q;
    assign cs_n        = cs_q;
    assign mosi        = (state == SQ_SHIFT && sending) ? shreg[BYTE_W-1] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            sending <= 1'b0;
            remain  <= '0;
            shreg   <= '0;
            samp    <= 1'b0;
            bitc    <= '0;
            hcnt    <= '0;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (!op_empty) begin
                        if (is_cs_cmd(op_head)) begin
                            cs_q <= (op_head.code == OPC_CS_HIGH);
                        end else if (is_xfer_cmd(op_head)) begin
                            remain  <= op_head.len;
                            sending <= (op_head.code == OPC_SEND);
                            state   <= SQ_LOAD;
                        end
                    end
                end
                SQ_LOAD: begin
                    bitc <= '0;
                    hcnt <= '0;
                    if (remain == '0) begin
                        state <= SQ_IDLE;
                    end else if (sending) begin
                        if (!d_empty) begin
                            shreg <= d_head;
                            state <= SQ_SHIFT;
                        end
                    end else begin
                        shreg <= '0;
                        state <= SQ_SHIFT;
                    end
                end
                SQ_SHIFT: begin
                    if (hcnt == HCW'(HALF - 1)) begin
                        hcnt   <= '0;
                        sclk_q <= !sclk_q;
                        if (!sclk_q) begin
                            samp <= miso;
                        end else begin
                            shreg <= {shreg[BYTE_W-2:0], samp};
                            bitc  <= bitc + BCW'(1);
                            if (bitc == BCW'(BYTE_W - 1)) begin
                                if (sending) begin
                                    remain <= remain - LEN_W'(1);
                                    state  <= SQ_LOAD;
                                end else begin
                                    state  <= SQ_STORE;
                                end
                            end
                        end
                    end else begin
                        hcnt <= hcnt + HCW'(1);
                    end
                end
                SQ_STORE: begin
                    if (!d_full) begin
                        remain <= remain - LEN_W'(1);
                        state  <= SQ_LOAD;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_SHIFT) |-> !sclk_q);

    a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
        sclk_q |-> $stable(mosi));

    a_r3_cs_steady_in_xfer: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_IDLE) |=> $stable(cs_q));

    a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_LOAD && sending && d_empty && remain != '0)
        |=> (state == SQ_LOAD && !sclk_q));

    a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STORE && d_full) |=> (state == SQ_STORE && $stable(shreg)));

    a_r5_pop_starts_byte: assert property (@(posedge clk) disable iff (rst)
        d_pop |=> (state == SQ_SHIFT));

endmodule

// File: rtl/spi_opseq.sv
`timescale 1ns/1ps
module spi_opseq
    import spi_opseq_pkg::*;
#(
    parameter int DW        = 32,
    parameter int CLK_DIV   = 4,
    parameter int OP_DEPTH  = 8,
    parameter int DAT_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    op_entry_t         op_word, op_head;
    logic              op_push, op_pop, op_full, op_empty;
    logic              sw_push, sw_pop;
    logic [BYTE_W-1:0] sw_byte;
    logic              eng_push, eng_pop;
    logic [BYTE_W-1:0] eng_byte;
    logic              dat_push, dat_pop, dat_full, dat_empty;
    logic [BYTE_W-1:0] dat_din, dat_head;

    spi_opseq_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .op_full   (op_full),
        .op_empty  (op_empty),
        .dat_full  (dat_full),
        .dat_empty (dat_empty),
        .dat_head  (dat_head),
        .op_push   (op_push),
        .op_word   (op_word),
        .sw_push   (sw_push),
        .sw_byte   (sw_byte),
        .sw_pop    (sw_pop)
    );

    spi_opseq_fifo #(.W(OP_W), .DEPTH(OP_DEPTH)) u_opq (
        .clk   (clk),
        .rst   (rst),
        .push  (op_push),
        .din   (op_word),
        .pop   (op_pop),
        .dout  (op_head),
        .full  (op_full),
        .empty (op_empty)
    );

    // the sequencer has priority on the shared byte queue
    assign dat_push = eng_push | sw_push;
    assign dat_din  = eng_push ? eng_byte : sw_byte;
    assign dat_pop  = eng_pop | sw_pop;

    spi_opseq_fifo #(.W(BYTE_W), .DEPTH(DAT_DEPTH)) u_datq (
        .clk   (clk),
        .rst   (rst),
        .push  (dat_push),
        .din   (dat_din),
        .pop   (dat_pop),
        .dout  (dat_head),
        .full  (dat_full),
        .empty (dat_empty)
    );

    spi_opseq_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .op_head     (op_head),
        .op_empty    (op_empty),
        .op_pop      (op_pop),
        .d_head      (dat_head),
        .d_empty     (dat_empty),
        .d_full      (dat_full),
        .d_pop       (eng_pop),
        .d_push      (eng_push),
        .d_push_data (eng_byte),
        .sclk        (spi_sclk),
        .cs_n        (spi_cs_n),
        .mosi        (spi_mosi),
        .miso        (spi_miso)
    );

    a_r11_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (spi_cs_n && !spi_sclk && op_empty && dat_empty));

endmodule

// File: tb/test_spi_opseq.sv
`timescale 1ns/1ps
module test_spi_opseq;

    localparam int DW = 32;
    localparam int CLK_DIV = 4;
    localparam real TCLK = 5.0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    bus_addr = '0;
    logic          bus_wen = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    spi_opseq #(.DW(DW), .CLK_DIV(CLK_DIV), .OP_DEPTH(8), .DAT_DEPTH(16)) i_spi_opseq (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    always #2.5 clk = ~clk;

    // ---------------- slave model ----------------
    int        rise_cnt = 0;
    int        fall_cnt = 0;
    logic [7:0] s_cap = '0;
    logic [7:0] cap_mem [256];
    realtime   last_rise = -1.0;
    realtime   min_per = 1.0e9;

    function automatic logic [7:0] resp(int k);
        return 8'((k * 37 + 5) % 256);
    endfunction

    assign spi_miso = resp(fall_cnt / 8)[7 - (fall_cnt % 8)];

    always @(posedge spi_sclk) begin
        s_cap = {s_cap[6:0], spi_mosi};
        rise_cnt = rise_cnt + 1;
        if (rise_cnt % 8 == 0) cap_mem[(rise_cnt / 8 - 1) % 256] = s_cap;
        if (last_rise >= 0.0 && ($realtime - last_rise) < min_per)
            min_per = $realtime - last_rise;
        last_rise = $realtime;
    end

    always @(negedge spi_sclk) fall_cnt = fall_cnt + 1;

    // ---------------- helpers ----------------
    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic push_op(logic [4:0] code, logic [8:0] len);
        wr(4'd0, DW'({code, len}));
        wr(4'd1, 1);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // {count, first byte}
    localparam logic [15:0] VEC [6] = '{
        16'h01A5, 16'h013C, 16'h0281, 16'h0100, 16'h03FD, 16'h015E
    };

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [DW-1:0] v;
        int rb, cb, fb, errs;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 cs_n", int'(spi_cs_n), 1);
        chk("R11 sclk", int'(spi_sclk), 0);
        chk("R11 mosi", int'(spi_mosi), 0);
        rd(4'd3, v); chk("R11 op empty", int'(v[0]), 1);
        rd(4'd2, v); chk("R11 op full", int'(v[0]), 0);
        rd(4'd7, v); chk("R11 dat empty", int'(v[0]), 1);
        rd(4'd5, v); chk("R11 dat full", int'(v[0]), 0);

        // R1: staging alone does nothing, push strobe does
        wr(4'd0, DW'({5'h01, 9'd1}));
        idle(10);
        chk("R1 staged only", int'(spi_cs_n), 1);
        rd(4'd0, v); chk("R1 staged word", int'(v[13:0]), int'({5'h01, 9'd1}));
        wr(4'd1, 1);
        idle(5);
        chk("R1/R3 cs low", int'(spi_cs_n), 0);
        rb = rise_cnt;
        push_op(5'h00, 9'd1);
        idle(5);
        chk("R3 cs high", int'(spi_cs_n), 1);
        chk("R3 no sclk", rise_cnt - rb, 0);

        // R4 table walk: send scripts
        for (int i = 0; i < 6; i++) begin
            int n;
            logic [7:0] b0;
            n  = int'(VEC[i][15:8]);
            b0 = VEC[i][7:0];
            for (int j = 0; j < n; j++) wr(4'd4, DW'(8'(b0 + 8'(j))));
            rb = rise_cnt;
            cb = rise_cnt / 8;
            push_op(5'h01, 9'd1);
            push_op(5'h08, 9'(n));
            push_op(5'h00, 9'd1);
            idle(n * 8 * CLK_DIV + 40);
            chk("R4 edge count", rise_cnt - rb, 8 * n);
            errs = 0;
            for (int j = 0; j < n; j++)
                if (cap_mem[(cb + j) % 256] != 8'(b0 + 8'(j))) errs++;
            chk("R4 bytes msb first", errs, 0);
            chk("R3 released", int'(spi_cs_n), 1);
        end
        chk("R4 sclk period", int'(min_per / TCLK), CLK_DIV);

        // R5 receive
        fb = fall_cnt / 8;
        push_op(5'h0C, 9'd3);
        idle(3 * 8 * CLK_DIV + 40);
        errs = 0;
        for (int j = 0; j < 3; j++) begin
            rd(4'd6, v);
            if (v[7:0] != resp(fb + j)) errs++;
            wr(4'd8, 1);
        end
        chk("R5 received bytes", errs, 0);
        rd(4'd7, v); chk("R5/R2 drained", int'(v[0]), 1);

        // R8 discards
        rb = rise_cnt;
        push_op(5'h0C, 9'd0);
        push_op(5'h1F, 9'd5);
        push_op(5'h01, 9'd2);
        idle(20);
        chk("R8 no sclk", rise_cnt - rb, 0);
        chk("R8 cs unchanged", int'(spi_cs_n), 1);
        rd(4'd3, v); chk("R8 op queue emptied", int'(v[0]), 1);

        // R9 + R6: fill command queue behind a stalled send
        rb = rise_cnt;
        cb = rise_cnt / 8;
        for (int k = 0; k < 9; k++) push_op(5'h08, 9'd1);
        rd(4'd2, v); chk("R9/R2 op full", int'(v[0]), 1);
        push_op(5'h08, 9'd1);
        idle(30);
        chk("R6 stalled no sclk", rise_cnt - rb, 0);
        chk("R6 sclk low", int'(spi_sclk), 0);
        for (int k = 0; k < 10; k++) wr(4'd4, DW'(8'h10 + 8'(k)));
        idle(9 * (8 * CLK_DIV + 4) + 60);
        chk("R9 tenth push ignored", rise_cnt - rb, 72);
        errs = 0;
        for (int k = 0; k < 9; k++)
            if (cap_mem[(cb + k) % 256] != 8'h10 + 8'(k)) errs++;
        chk("R6 resumed bytes", errs, 0);
        rd(4'd6, v); chk("R9 leftover byte", int'(v[7:0]), 8'h19);
        wr(4'd8, 1);

        // R10 byte queue limits
        for (int k = 0; k < 17; k++) wr(4'd4, DW'(8'h40 + 8'(k)));
        rd(4'd5, v); chk("R10/R2 dat full", int'(v[0]), 1);
        errs = 0;
        for (int k = 0; k < 16; k++) begin
            rd(4'd6, v);
            if (v[7:0] != 8'h40 + 8'(k)) errs++;
            wr(4'd8, 1);
        end
        chk("R10 order and overflow drop", errs, 0);
        rd(4'd7, v); chk("R10 empty after 16", int'(v[0]), 1);
        wr(4'd8, 1);
        wr(4'd4, DW'(8'h77));
        rd(4'd6, v); chk("R10 pop on empty ignored", int'(v[7:0]), 8'h77);
        rd(4'd7, v); chk("R10 one byte held", int'(v[0]), 0);
        wr(4'd8, 1);

        // R7 receive stalls on a full byte queue
        rb = rise_cnt;
        fb = fall_cnt / 8;
        push_op(5'h0C, 9'd18);
        idle(17 * (8 * CLK_DIV + 4) + 200);
        chk("R7 sclk halted", rise_cnt - rb, 136);
        rd(4'd5, v); chk("R7 dat full", int'(v[0]), 1);
        errs = 0;
        for (int k = 0; k < 16; k++) begin
            rd(4'd6, v);
            if (v[7:0] != resp(fb + k)) errs++;
            wr(4'd8, 1);
        end
        idle(2 * 8 * CLK_DIV + 60);
        for (int k = 16; k < 18; k++) begin
            rd(4'd6, v);
            if (v[7:0] != resp(fb + k)) errs++;
            wr(4'd8, 1);
        end
        chk("R7 no byte lost", errs, 0);
        chk("R7 total edges", rise_cnt - rb, 144);
        rd(4'd7, v); chk("R7 drained", int'(v[0]), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule